// File: doc/BRIEF.md
# PHY Test-Port Register Slave

This block is the register end of a slow strobe-driven configuration port that a controller uses to program a receiver PHY. The controller drives an 8-bit byte bus, an enable level, a strobe line and a clear line. A write has two phases. In the first, the strobe falls while the enable is high, and the byte on the bus becomes the register code. In the second, the strobe rises while the enable is low, and the byte on the bus is stored in the register that the code selects. A read-back bus always shows the register that the latched code selects.

The strobe and clear lines are asynchronous to the system clock. Both pass through a synchronizer before any edge is detected. The byte bus and the enable level are assumed to stay stable while a strobe edge crosses the synchronizer.

The block holds the following registers:
- one clock-lane receiver control byte,
- one control byte per data lane, whose bits 6:1 form the lane's frequency-band code,
- one settle-count threshold byte.

These registers drive the outputs of the block. Code 0x00 is the normal-operation code and is reported on its own output.

Top module: `tp_cfg_slave`

## Requirements
- R1: After a synchronous reset, every control output and the read-back bus are zero, and the normal-mode output is 1.
- R2: When the synchronized strobe falls while the enable is high, the byte on the bus becomes the latched code.
- R3: When the synchronized strobe rises while the enable is low, the byte on the bus is stored in the register at the latched code, and the read-back bus then shows it.
- R4: A rising strobe with the enable high changes no state. A falling strobe with the enable low also changes no state. The read-back value and the control outputs stay unchanged.
- R5: Code 0x34 holds the clock-lane control byte, which drives the clock-lane output unchanged.
- R6: Codes 0x44, 0x54, 0x84 and 0x94 hold the control bytes of lanes 0 to 3. Bits 6:1 of lane n's byte drive the 6-bit band field n of the band output, and field 0 is the least significant.
- R7: Code 0x75 holds the settle-count threshold byte, which drives the threshold output.
- R8: A write to any other code, 0x00 included, is ignored, and the read-back bus shows zero for that code.
- R9: Holding the clear line high zeroes the latched code and all registers.
- R10: The normal-mode output is 1 exactly when the latched code is 0x00.
- R11: With two synchronizer stages, a write becomes visible on the third system-clock edge after the strobe changes at the pin, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tp_din | input | 8 | Code or data byte from the controller |
| tp_en | input | 1 | High in the code phase, low in the data phase |
| tp_clk | input | 1 | Asynchronous strobe line |
| tp_clr | input | 1 | Asynchronous clear of the test logic |
| tp_dout | output | 8 | Register selected by the latched code, or zero |
| clk_lane_ctl | output | 8 | Clock-lane control byte |
| lane_band | output | NUM_LANES*6 | Per-lane band codes, lane 0 in the lowest field |
| settle_thr | output | 8 | Settle-count threshold |
| normal_mode | output | 1 | Latched code is 0x00 |

## Verification
The bench builds the block with its defaults: four lanes and two synchronizer stages. With four lanes, every lane code can be written, and the packing of every band field can be checked. With two stages, the bench can predict the three-edge write latency exactly. It checks that the write is absent after two edges and present after three.

// File: rtl/tp_pkg.sv
// Package: shared widths and register codes for the test-port slave.
// Assumes at most four lanes; lane codes beyond index 3 map to 0x00.
package tp_pkg;
    localparam int BYTE_W      = 8;
    localparam int BAND_W      = 6;
    localparam int MAX_LANES   = 4;
    localparam logic [BYTE_W-1:0] CODE_NORMAL = 8'h00;
    localparam logic [BYTE_W-1:0] CODE_CKLANE = 8'h34;
    localparam logic [BYTE_W-1:0] CODE_SETTLE = 8'h75;

    // Maps a lane index to the code of its receiver control byte.
    function automatic logic [BYTE_W-1:0] lane_code(input int idx);
        case (idx)
            0:       lane_code = 8'h44;
            1:       lane_code = 8'h54;
            2:       lane_code = 8'h84;
            3:       lane_code = 8'h94;
            default: lane_code = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/tp_sync.sv
// Module: multi-bit level synchronizer, STAGES flops deep.
// Assumes each bit is an independent slow level, so there is no coherence between bits.
module tp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    // First stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-samples the stage before it.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tp_strobe_dec.sv
// Module: strobe edge decoder and code latch.
// Turns the synchronized strobe into a capture pulse (falling edge, enable high)
// and a write pulse (rising edge, enable low), and holds the latched code.
// Assumes the byte bus and the enable are stable while an edge is in flight.
module tp_strobe_dec
    import tp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              strobe_i,
    input  logic              en_i,
    input  logic [BYTE_W-1:0] din_i,
    output logic              wr_o,
    output logic [BYTE_W-1:0] code_o
);
    logic              strobe_d;
    logic              cap;
    logic [BYTE_W-1:0] code_q;

    // Keeps last cycle's strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_d <= 1'b0;
        else        strobe_d <= strobe_i;
    end

    assign cap  = !strobe_i &&  strobe_d &&  en_i;
    assign wr_o =  strobe_i && !strobe_d && !en_i && !clr_i;

    // Loads the code on a capture pulse, and zeroes it on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) code_q <= '0;
        else if (cap)        code_q <= din_i;
    end

    assign code_o = code_q;

    a_r2_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !cap) |=> $stable(code_q));
    a_r11_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o);
endmodule

// File: rtl/tp_reg_bank.sv
// Module: register array for the test port.
// Holds the clock-lane byte, one byte per lane and the settle threshold.
// It decodes the write code and builds the read-back value.
// Assumes wr_i is a single-cycle pulse; clear has priority over a write.
module tp_reg_bank
    import tp_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_i,
    input  logic                        wr_i,
    input  logic [BYTE_W-1:0]           code_i,
    input  logic [BYTE_W-1:0]           data_i,
    output logic [BYTE_W-1:0]           rdata_o,
    output logic [BYTE_W-1:0]           cklane_o,
    output logic [NUM_LANES*BAND_W-1:0] band_o,
    output logic [BYTE_W-1:0]           settle_o
);
    logic [BYTE_W-1:0] cklane_q;
    logic [BYTE_W-1:0] settle_q;
    logic [BYTE_W-1:0] lane_q [NUM_LANES];

    // Clock-lane control byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)                    cklane_q <= '0;
        else if (wr_i && code_i == CODE_CKLANE) cklane_q <= data_i;
    end

    // Settle-count threshold byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)                    settle_q <= '0;
        else if (wr_i && code_i == CODE_SETTLE) settle_q <= data_i;
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        localparam logic [BYTE_W-1:0] MY_CODE = lane_code(l);
        // Per-lane receiver control byte.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i)                lane_q[l] <= '0;
            else if (wr_i && code_i == MY_CODE) lane_q[l] <= data_i;
        end
        assign band_o[l*BAND_W +: BAND_W] = lane_q[l][BAND_W:1];
    end

    // Read-back multiplexer: zero for any code without a register.
    always_comb begin
        rdata_o = '0;
        if (code_i == CODE_CKLANE) rdata_o = cklane_q;
        if (code_i == CODE_SETTLE) rdata_o = settle_q;
        for (int l = 0; l < NUM_LANES; l++) begin
            if (code_i == lane_code(l)) rdata_o = lane_q[l];
        end
    end

    assign cklane_o = cklane_q;
    assign settle_o = settle_q;

    a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !wr_i) |=> ($stable(cklane_q) && $stable(settle_q)));
    a_r7_settle_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && wr_i && code_i == CODE_SETTLE) |=> (settle_q == $past(data_i)));
    a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cklane_q == '0 && settle_q == '0));
endmodule

// File: rtl/tp_cfg_slave.sv
// Module: top of the PHY test-port register slave.
// Synchronizes the strobe and clear lines and decodes strobe edges into
// code captures and writes. It drives the control outputs from the register bank.
// Assumes 1 <= NUM_LANES <= 4 and SYNC_STAGES >= 2.
module tp_cfg_slave
    import tp_pkg::*;
#(
    parameter int NUM_LANES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [7:0]                  tp_din,
    input  logic                        tp_en,
    input  logic                        tp_clk,
    input  logic                        tp_clr,
    output logic [7:0]                  tp_dout,
    output logic [7:0]                  clk_lane_ctl,
    output logic [NUM_LANES*6-1:0]      lane_band,
    output logic [7:0]                  settle_thr,
    output logic                        normal_mode
);
    logic [1:0]        sync_lv;
    logic              wr;
    logic [BYTE_W-1:0] code;

    tp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({tp_clr, tp_clk}),
        .sync_o  (sync_lv)
    );

    tp_strobe_dec u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (sync_lv[1]),
        .strobe_i (sync_lv[0]),
        .en_i     (tp_en),
        .din_i    (tp_din),
        .wr_o     (wr),
        .code_o   (code)
    );

    tp_reg_bank #(.NUM_LANES(NUM_LANES)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (sync_lv[1]),
        .wr_i     (wr),
        .code_i   (code),
        .data_i   (tp_din),
        .rdata_o  (tp_dout),
        .cklane_o (clk_lane_ctl),
        .band_o   (lane_band),
        .settle_o (settle_thr)
    );

    assign normal_mode = (code == CODE_NORMAL);

    a_r9_clear_code: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lv[1] |=> normal_mode);
endmodule

// File: tb/tp_cfg_slave_bench.sv
module tp_cfg_slave_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tp_din = 8'h00;
    logic        tp_en = 1'b1;
    logic        tp_clk = 1'b1;
    logic        tp_clr = 1'b0;
    logic [7:0]  tp_dout;
    logic [7:0]  clk_lane_ctl;
    logic [23:0] lane_band;
    logic [7:0]  settle_thr;
    logic        normal_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tp_cfg_slave u_tp_cfg_slave (
        .clk(clk), .rst_n(rst_n), .tp_din(tp_din), .tp_en(tp_en),
        .tp_clk(tp_clk), .tp_clr(tp_clr), .tp_dout(tp_dout),
        .clk_lane_ctl(clk_lane_ctl), .lane_band(lane_band),
        .settle_thr(settle_thr), .normal_mode(normal_mode)
    );

    // Each vector is {code, data, expected read-back}.
    localparam logic [23:0] VEC [8] = '{
        {8'h34, 8'hA5, 8'hA5},   // R5
        {8'h44, 8'h14, 8'h14},   // R6 lane 0
        {8'h54, 8'h7E, 8'h7E},   // R6 lane 1
        {8'h84, 8'h02, 8'h02},   // R6 lane 2
        {8'h94, 8'hFF, 8'hFF},   // R6 lane 3
        {8'h75, 8'h04, 8'h04},   // R7
        {8'h10, 8'h55, 8'h00},   // R8 unimplemented
        {8'h00, 8'h33, 8'h00}    // R8 normal code
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tp_write(input logic [7:0] code, input logic [7:0] data);
        tp_din = code; tp_en = 1'b1; tp_clk = 1'b0; settle();
        tp_en = 1'b0; tp_din = data; tp_clk = 1'b1; settle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1: reset state
        chk("R1 dout", tp_dout, 0);
        chk("R1 outputs", {clk_lane_ctl, settle_thr}, 0);
        chk("R1 bands", lane_band, 0);
        chk("R1 normal", normal_mode, 1);

        foreach (VEC[i]) begin
            tp_write(VEC[i][23:16], VEC[i][15:8]);
            chk("R3 readback", tp_dout, VEC[i][7:0]);
        end
        chk("R10 normal at 0x00", normal_mode, 1);
        chk("R5 clock lane", clk_lane_ctl, 8'hA5);
        chk("R6 bands", lane_band, {6'h3F, 6'h01, 6'h3F, 6'h0A});
        chk("R7 settle", settle_thr, 8'h04);

        // R2: code capture alone (fall with enable high)
        tp_din = 8'h75; tp_en = 1'b1; tp_clk = 1'b0; settle();
        chk("R2 capture", tp_dout, 8'h04);
        chk("R10 not normal", normal_mode, 0);

        // R4: fall with enable low, then rise with enable high
        tp_clk = 1'b1; settle();
        tp_en = 1'b0; tp_din = 8'h11; tp_clk = 1'b0; settle();
        chk("R4 fall enable low", tp_dout, 8'h04);
        tp_en = 1'b1; tp_din = 8'h22; tp_clk = 1'b1; settle();
        chk("R4 rise enable high", {tp_dout, settle_thr}, 16'h0404);

        // R11: write latency of three edges
        tp_din = 8'h34; tp_en = 1'b1; tp_clk = 1'b0; settle();
        tp_en = 1'b0; tp_din = 8'h3C; tp_clk = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 not yet", clk_lane_ctl, 8'hA5);
        @(posedge clk);
        @(negedge clk);
        chk("R11 visible", clk_lane_ctl, 8'h3C);
        settle();

        // R9: clear
        tp_clr = 1'b1; settle();
        tp_clr = 1'b0; settle();
        chk("R9 registers", {clk_lane_ctl, settle_thr}, 0);
        chk("R9 bands", lane_band, 0);
        chk("R9 code", {tp_dout, 7'd0, normal_mode}, 16'h0001);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R3 watchdog: actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule